// File: doc/BRIEF.md
# Two-Phase Data Bus Interface

This block sits on the data side of a small CPU whose work is split into two non-overlapping phases of one system clock. It holds three registers: an outgoing data register that takes the ALU result, and a pair of capture registers (an inbound data latch and an opcode predecode register) that take whatever is on the data bus. The outgoing register loads in phase one. The capture pair loads in phase two. This leaves a whole phase for a value to pass from the capture latch, through the ALU and back into the outgoing register.

Every bus cycle is either a read or a write. A write cycle drives the outgoing register onto the pins during phase two only. Because the capture pair always loads in phase two, a write cycle also copies the driven value back into the latch and the predecode register. This causes no harm: each instruction starts with an opcode fetch, which is a read, and that read replaces the looped-back value. The bidirectional pins are modelled as a separate input, an output and an output enable.

Top module: `dbus_iface`

## Requirements
- R1: A synchronous active-high reset clears the outgoing register, the inbound latch and the predecode register to zero. After reset, with both phases low, the output enable is low and the bus output is zero.
- R2: On a clock edge with phase one high, the outgoing register takes `alu_res`. That value is what a later write cycle drives onto `bus_out`.
- R3: On a clock edge with phase one low, the outgoing register keeps its value whatever `alu_res` carries.
- R4: `bus_oe` is high exactly when `rw_write` is 1 (write) and phase two is high. While `bus_oe` is low, `bus_out` is all zeros. While it is high, `bus_out` equals the outgoing register.
- R5: On a clock edge with phase two high and `rw_write` = 0 (read), both the inbound latch and the predecode register take `bus_in`.
- R6: On a clock edge with phase two high and `rw_write` = 1 (write), both capture registers take the outgoing register value, and `bus_in` is ignored.
- R7: On a clock edge with phase two low, both capture registers keep their values.
- R8: A read cycle that follows a write cycle replaces the looped-back value in both capture registers with the external bus value.
- R9: The predecode register always equals the inbound latch after any phase-two load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ph1_en | input | 1 | Phase-one enable |
| ph2_en | input | 1 | Phase-two enable |
| rw_write | input | 1 | Cycle direction, 1 = write, 0 = read |
| alu_res | input | DATA_W | Result from the ALU to be stored for output |
| bus_in | input | DATA_W | Value sampled from the external data pins |
| bus_out | output | DATA_W | Value driven onto the external data pins |
| bus_oe | output | 1 | Tristate driver enable for the data pins |
| data_latch | output | DATA_W | Inbound data latch contents |
| predecode | output | DATA_W | Opcode predecode register contents |

## Verification
The bench builds the block with `DATA_W` = 4. This makes it possible to sweep every pairing of outgoing value and external bus value in both read and write cycles, a few hundred combinations in all. Between the phase-one load and the phase-two cycle, the bench puts the complement of the stored value on the ALU input. This shows that the outgoing register holds. A dead cycle after each transfer, with a fresh bus value, shows that the capture pair holds. Because the sweep alternates directions, every write is followed by a read, which covers the opcode fetch that replaces a looped-back value.

// File: rtl/dbus_pkg.sv
package dbus_pkg;
  typedef enum logic {
    CYC_READ  = 1'b0,
    CYC_WRITE = 1'b1
  } cyc_dir_e;
endpackage

// File: rtl/dbus_out_reg.sv
module dbus_out_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (ld_en) q <= d;
  end

  a_r2_out_load: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (q == $past(d)));
  a_r3_out_hold: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> $stable(q));
endmodule

// File: rtl/dbus_capture.sv
module dbus_capture
  import dbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  cyc_dir_e          dir,
  input  logic [DATA_W-1:0] ext_d,
  input  logic [DATA_W-1:0] loop_d,
  output logic [DATA_W-1:0] latch_q,
  output logic [DATA_W-1:0] pre_q
);
  localparam int N_COPIES = 2;

  logic [DATA_W-1:0] sel_d;
  logic [DATA_W-1:0] copy_q [N_COPIES];

  always_comb sel_d = (dir == CYC_WRITE) ? loop_d : ext_d;

  for (genvar g = 0; g < N_COPIES; g++) begin : g_copy
    always_ff @(posedge clk) begin
      if (rst)        copy_q[g] <= '0;
      else if (ld_en) copy_q[g] <= sel_d;
    end
  end

  assign latch_q = copy_q[0];
  assign pre_q   = copy_q[1];

  a_r5_read_capture: assert property (@(posedge clk) disable iff (rst)
    (ld_en && dir == CYC_READ) |=> (latch_q == $past(ext_d)));
  a_r6_write_loop: assert property (@(posedge clk) disable iff (rst)
    (ld_en && dir == CYC_WRITE) |=> (latch_q == $past(loop_d)));
  a_r7_capture_hold: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> ($stable(latch_q) && $stable(pre_q)));
  a_r9_pre_match: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (pre_q == latch_q));
endmodule

// File: rtl/dbus_driver.sv
module dbus_driver
  import dbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  cyc_dir_e          dir,
  input  logic              ph2_en,
  input  logic [DATA_W-1:0] src,
  output logic              oe,
  output logic [DATA_W-1:0] drv
);
  always_comb begin
    oe  = (dir == CYC_WRITE) && ph2_en;
    drv = oe ? src : '0;
  end
endmodule

// File: rtl/dbus_iface.sv
module dbus_iface
  import dbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ph1_en,
  input  logic              ph2_en,
  input  logic              rw_write,
  input  logic [DATA_W-1:0] alu_res,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [DATA_W-1:0] data_latch,
  output logic [DATA_W-1:0] predecode
);
  cyc_dir_e          dir;
  logic [DATA_W-1:0] dout_q;

  assign dir = cyc_dir_e'(rw_write);

  dbus_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .ld_en(ph1_en), .d(alu_res), .q(dout_q)
  );

  dbus_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .ld_en(ph2_en), .dir(dir),
    .ext_d(bus_in), .loop_d(dout_q),
    .latch_q(data_latch), .pre_q(predecode)
  );

  dbus_driver #(.DATA_W(DATA_W)) u_drv (
    .dir(dir), .ph2_en(ph2_en), .src(dout_q), .oe(bus_oe), .drv(bus_out)
  );

  a_r4_oe_gate: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (ph2_en && rw_write));
  a_r4_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_out == '0));
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (data_latch == '0 && predecode == '0));
endmodule

// File: tb/dbus_iface_bench.sv
module dbus_iface_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int NVAL = 1 << W;

  logic         clk = 1'b0;
  logic         rst, ph1_en, ph2_en, rw_write;
  logic [W-1:0] alu_res, bus_in, bus_out, data_latch, predecode;
  logic         bus_oe;
  int           checks = 0;
  int           errors = 0;
  bit           done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbus_iface #(.DATA_W(W)) u_dbus_iface (
    .clk(clk), .rst(rst), .ph1_en(ph1_en), .ph2_en(ph2_en),
    .rw_write(rw_write), .alu_res(alu_res), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe),
    .data_latch(data_latch), .predecode(predecode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int lat;
    rst = 1; ph1_en = 0; ph2_en = 0; rw_write = 0; alu_res = '0; bus_in = '0;
    @(negedge clk);
    tick();
    rst = 0;
    #1;
    chk("R1 latch", int'(data_latch), 0);
    chk("R1 predecode", int'(predecode), 0);
    chk("R1 oe", int'(bus_oe), 0);
    chk("R1 bus_out", int'(bus_out), 0);
    lat = 0;
    for (int a = 0; a < NVAL; a++) begin
      for (int b = 0; b < NVAL; b++) begin
        for (int w = 0; w < 2; w++) begin
          // phase one: load the outgoing register
          ph1_en = 1; ph2_en = 0; alu_res = W'(a); rw_write = 0; bus_in = W'(b);
          tick();
          // dead cycle: ALU value changes, register must hold (R3)
          ph1_en = 0; alu_res = ~W'(a);
          tick();
          // phase two cycle
          ph2_en = 1; rw_write = w[0]; bus_in = W'(b);
          #1;
          chk("R4 oe", int'(bus_oe), w);
          chk("R4 bus_out", int'(bus_out), w ? a : 0);
          if (w == 1) chk("R2/R3 driven value", int'(bus_out), a);
          tick();
          lat = w ? a : b;
          if (w == 1) chk("R6 loopback latch", int'(data_latch), lat);
          else        chk("R5 read latch", int'(data_latch), lat);
          chk("R9 predecode", int'(predecode), lat);
          // hold check: phase two low, new bus value
          ph2_en = 0; rw_write = 0; bus_in = ~W'(b);
          #1;
          chk("R4 idle oe", int'(bus_oe), 0);
          tick();
          chk("R7 latch hold", int'(data_latch), lat);
          chk("R7 predecode hold", int'(predecode), lat);
        end
        // R8: write then read; the read must replace the looped value
        chk("R8 after write", int'(data_latch), a);
        ph2_en = 1; rw_write = 0; bus_in = W'(b ^ 5);
        tick();
        ph2_en = 0;
        chk("R8 opcode fetch latch", int'(data_latch), b ^ 5);
        chk("R8 opcode fetch predecode", int'(predecode), b ^ 5);
      end
    end
    // mid-run reset
    rst = 1;
    tick();
    rst = 0;
    chk("R1 mid-run latch", int'(data_latch), 0);
    chk("R1 mid-run predecode", int'(predecode), 0);
    ph2_en = 1; rw_write = 1;
    #1;
    chk("R1 cleared outgoing register", int'(bus_out), 0);
    ph2_en = 0; rw_write = 0;
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule